// File: doc/BRIEF.md
# Timer Channel Event Flags and Interrupt Request

One counter channel of a general-purpose timer that watches for three kinds of event and turns each into a sticky status flag: the counter reaching a programmed compare value, the counter wrapping from its all-ones value back to zero, and a transition of polarity chosen by software on an external input pin. Each flag has its own enable bit. A single registered interrupt line is raised whenever any flag is set while its enable is on.

Software reaches the channel through a plain single-cycle register port with four words: the counter, the compare value, a channel control/status word and a comparator control/status word. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Reads are combinational from `bus_addr`. The port has no back-pressure: every access completes in the cycle it is presented, so it has no valid/ready pair. A flag is cleared by writing zero to its bit. Writing one to a flag bit leaves the flag as it is. The other fields of the same word are written normally.

The external pin is asynchronous. It passes through a synchronizer before the edge detector, which fires once per qualifying transition.

Top module: `tmr_chan_irq`

## Requirements
- R1: After reset the counter reads 0x0000, the compare word reads 0xFFFF, both control/status words read 0x0000 and `irq` is low.
- R2: The counter (address 0) adds one at every clock edge while the run bit (address 2, bit 0) is set and holds while it is clear; a write to address 0 loads the written value and takes priority over counting.
- R3: When the counter steps from 0xFFFF to 0x0000 the overflow flag (address 2, bit 8) is set, and it is visible after the same clock edge that shows the counter at zero.
- R4: While running, a cycle in which the counter equals the compare word (address 1) sets the compare flag (address 3, bit 8) at the following clock edge.
- R5: The pin polarity bit (address 2, bit 3; 1 = rising, 0 = falling) selects which pin transition counts; the edge flag (address 2, bit 9) becomes visible after the third clock edge following the pin change, and the opposite transition leaves the flag clear.
- R6: Writing 0 to a flag bit clears that flag; writing 1 to it leaves the flag unchanged, while the other bits of the same word take the written value.
- R7: If a flag's event occurs in the same cycle as a write that clears that flag, the flag stays set.
- R8: `irq` is a register holding the OR of each flag ANDed with its enable (overflow enable address 2 bit 1, edge enable address 2 bit 2, compare enable address 3 bit 0); it rises one clock edge after a flag/enable pair becomes true, falls one edge after the last pair goes false, and stays low for a flag whose enable is off.
- R9: A single pin transition sets the edge flag only once: after the flag is cleared it stays clear while the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with `bus_sel` |
| bus_addr | input | 2 | Word select: 0 counter, 1 compare, 2 channel control/status, 3 comparator control/status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ev_pin | input | 1 | Asynchronous external event pin |
| irq | output | 1 | Registered combined interrupt request |

## Verification
A counter that loses or gains a step shows up at the first read of address 0 after a stopped run, since every run in the bench has a known length. A flag that sets without its event, or misses one, shows up at the next read of its status word. These reads are timed to the exact clock edge at which each event should have landed, so an off-by-one in the synchronizer or compare path is caught within one cycle. A wrong enable mask or an unregistered `irq` shows as `irq` rising or falling one edge early or late around a set or a clear.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  // register word select
  localparam int unsigned REG_CNT   = 0;
  localparam int unsigned REG_CMP   = 1;
  localparam int unsigned REG_CTRL  = 2;
  localparam int unsigned REG_CCTRL = 3;

  // channel control/status bit positions
  localparam int unsigned CTRL_RUN      = 0;
  localparam int unsigned CTRL_OVF_IE   = 1;
  localparam int unsigned CTRL_EDGE_IE  = 2;
  localparam int unsigned CTRL_EDGE_POL = 3;
  localparam int unsigned CTRL_OVF_FLG  = 8;
  localparam int unsigned CTRL_EDGE_FLG = 9;

  // comparator control/status bit positions
  localparam int unsigned CCTRL_CMP_IE  = 0;
  localparam int unsigned CCTRL_CMP_FLG = 8;

  // event slots
  localparam int unsigned EV_CMP  = 0;
  localparam int unsigned EV_OVF  = 1;
  localparam int unsigned EV_EDGE = 2;
  localparam int unsigned NUM_EVT = 3;

  typedef struct packed {
    logic run;
    logic ovf_ie;
    logic edge_ie;
    logic edge_pol;
    logic cmp_ie;
  } chan_cfg_t;

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         cmp_evt
);

  localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // wrap only when the step really happens
  assign ovf_evt = run & ~load & (cnt_q == CNT_TOP);
  assign cmp_evt = run & (cnt_q == cmp_val);
  assign cnt     = cnt_q;

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_evt
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= IDLE;
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {STAGES{IDLE}};
        else        sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  assign edge_evt = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);

endmodule

// File: rtl/tmr_sticky_flag.sv
module tmr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);

  logic flag_q;

  // an event in the clearing cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign flag = flag_q;

endmodule

// File: rtl/tmr_chan_irq.sv
module tmr_chan_irq
  import tmr_chan_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          PIN_IDLE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_pin,
  output logic              irq
);

  localparam logic [CNT_W-1:0] CMP_RST = {CNT_W{1'b1}};

  logic wr_any;
  logic wr_cnt, wr_cmp, wr_ctrl, wr_cctrl;

  assign wr_any   = bus_sel & bus_wr;
  assign wr_cnt   = wr_any & (bus_addr == ADDR_W'(REG_CNT));
  assign wr_cmp   = wr_any & (bus_addr == ADDR_W'(REG_CMP));
  assign wr_ctrl  = wr_any & (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_cctrl = wr_any & (bus_addr == ADDR_W'(REG_CCTRL));

  // configuration fields
  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] cmp_q;
  logic             run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.run      <= bus_wdata[CTRL_RUN];
        cfg_q.ovf_ie   <= bus_wdata[CTRL_OVF_IE];
        cfg_q.edge_ie  <= bus_wdata[CTRL_EDGE_IE];
        cfg_q.edge_pol <= bus_wdata[CTRL_EDGE_POL];
      end
      if (wr_cctrl) begin
        cfg_q.cmp_ie   <= bus_wdata[CCTRL_CMP_IE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= CMP_RST;
    else if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
  end

  assign run_en = cfg_q.run;

  // counter and its two events
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_EVT-1:0] evt;

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .load     (wr_cnt),
    .load_val (bus_wdata[CNT_W-1:0]),
    .cmp_val  (cmp_q),
    .cnt      (cnt_q),
    .ovf_evt  (evt[EV_OVF]),
    .cmp_evt  (evt[EV_CMP])
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ev_pin),
    .rise_sel (cfg_q.edge_pol),
    .edge_evt (evt[EV_EDGE])
  );

  // clear requests: a written zero in a flag position
  logic [NUM_EVT-1:0] clr;
  logic [NUM_EVT-1:0] flag_q;
  logic [NUM_EVT-1:0] ens;

  assign clr[EV_CMP]  = wr_cctrl & ~bus_wdata[CCTRL_CMP_FLG];
  assign clr[EV_OVF]  = wr_ctrl  & ~bus_wdata[CTRL_OVF_FLG];
  assign clr[EV_EDGE] = wr_ctrl  & ~bus_wdata[CTRL_EDGE_FLG];

  assign ens[EV_CMP]  = cfg_q.cmp_ie;
  assign ens[EV_OVF]  = cfg_q.ovf_ie;
  assign ens[EV_EDGE] = cfg_q.edge_ie;

  generate
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
      tmr_sticky_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (evt[k]),
        .clr_req (clr[k]),
        .flag    (flag_q[k])
      );
    end
  endgenerate

  // combined request, registered
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flag_q & ens);
  end

  assign irq = irq_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(REG_CNT): bus_rdata[CNT_W-1:0] = cnt_q;
      ADDR_W'(REG_CMP): bus_rdata[CNT_W-1:0] = cmp_q;
      ADDR_W'(REG_CTRL): begin
        bus_rdata[CTRL_RUN]      = cfg_q.run;
        bus_rdata[CTRL_OVF_IE]   = cfg_q.ovf_ie;
        bus_rdata[CTRL_EDGE_IE]  = cfg_q.edge_ie;
        bus_rdata[CTRL_EDGE_POL] = cfg_q.edge_pol;
        bus_rdata[CTRL_OVF_FLG]  = flag_q[EV_OVF];
        bus_rdata[CTRL_EDGE_FLG] = flag_q[EV_EDGE];
      end
      default: begin
        bus_rdata[CCTRL_CMP_IE]  = cfg_q.cmp_ie;
        bus_rdata[CCTRL_CMP_FLG] = flag_q[EV_CMP];
      end
    endcase
  end

endmodule

// File: rtl/tmr_chan_irq_chk.sv
module tmr_chan_irq_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       evt,
  input logic [2:0]       flags,
  input logic [2:0]       ens,
  input logic             irq
);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !load |=> $stable(cnt));

  a_r3_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && (cnt == {CNT_W{1'b1}}) |=> flags[1] && (cnt == '0));

  a_r8_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(flags & ens)));

  a_r9_edge_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    evt[2] |=> !evt[2]);

  generate
    for (genvar k = 0; k < 3; k++) begin : g_flag_chk
      // R7: event wins over any clear
      a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt[k] |=> flags[k]);
      // R6: a flag never sets without its event
      a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[k] && !evt[k] |=> !flags[k]);
    end
  endgenerate

endmodule

bind tmr_chan_irq tmr_chan_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run_en),
  .load  (wr_cnt),
  .cnt   (cnt_q),
  .evt   (evt),
  .flags (flag_q),
  .ens   (ens),
  .irq   (irq)
);

// File: tb/tmr_chan_irq_tb.sv
`timescale 1ns/100ps
module tmr_chan_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        ev_pin = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  tmr_chan_irq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_pin    (ev_pin),
    .irq       (irq)
  );

  localparam int SEL_IRQ = 4;

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    item_t       it;
    logic [15:0] act;
    if (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = (it.sel == SEL_IRQ) ? {15'h0, irq} : bus_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d: got %h expected %h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: push one expected item, let the monitor take it
  task automatic expect_val(input string req, input int sel, input logic [15:0] e);
    item_t it;
    if (sel != SEL_IRQ) bus_addr = sel[1:0];
    it.req = req; it.sel = sel; it.exp = e;
    sb_q.push_back(it);
    tick(1);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      report();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    expect_val("R1", 0, 16'h0000);
    expect_val("R1", 1, 16'hFFFF);
    expect_val("R1", 2, 16'h0000);
    expect_val("R1", 3, 16'h0000);
    expect_val("R1", SEL_IRQ, 16'h0000);

    // R2 counting, hold, load priority
    wr(2'd0, 16'h0010);
    wr(2'd2, 16'h0001);
    tick(5);
    wr(2'd2, 16'h0000);
    expect_val("R2", 0, 16'h0016);
    expect_val("R2", 0, 16'h0016);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'h0000);
    expect_val("R2", 0, 16'h1235);

    // R3 wrap, R4 compare at 0xFFFF, R8 no irq without enable
    wr(2'd0, 16'hFFFD);
    wr(2'd2, 16'h0001);
    tick(2);
    wr(2'd2, 16'h0000);
    expect_val("R3", 2, 16'h0100);
    expect_val("R3", 0, 16'h0000);
    expect_val("R4", 3, 16'h0100);
    expect_val("R8", SEL_IRQ, 16'h0000);

    // R6 write one keeps, write zero clears
    wr(2'd2, 16'h0100);
    expect_val("R6", 2, 16'h0100);
    wr(2'd3, 16'h0100);
    expect_val("R6", 3, 16'h0100);
    wr(2'd2, 16'h0000);
    expect_val("R6", 2, 16'h0000);
    wr(2'd3, 16'h0000);
    expect_val("R6", 3, 16'h0000);

    // R4 / R8 compare with enable, irq lag on set and clear
    wr(2'd3, 16'h0001);
    wr(2'd1, 16'h0005);
    wr(2'd0, 16'h0003);
    wr(2'd2, 16'h0001);
    tick(3);
    wr(2'd2, 16'h0000);
    expect_val("R8", SEL_IRQ, 16'h0001);
    expect_val("R4", 3, 16'h0101);
    expect_val("R2", 0, 16'h0007);
    wr(2'd3, 16'h0001);
    expect_val("R8", SEL_IRQ, 16'h0001);
    expect_val("R8", SEL_IRQ, 16'h0000);
    expect_val("R6", 3, 16'h0001);

    // R7 clear in the event cycle loses
    wr(2'd1, 16'h0020);
    wr(2'd0, 16'h001E);
    wr(2'd2, 16'h0001);
    tick(2);
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'h0000);
    expect_val("R7", 3, 16'h0100);
    expect_val("R2", 0, 16'h0022);
    wr(2'd3, 16'h0000);
    expect_val("R6", 3, 16'h0000);

    // R5 rising polarity, timing through the synchronizer
    wr(2'd2, 16'h000C);
    ev_pin = 1'b1;
    tick(2);
    expect_val("R5", 2, 16'h000C);
    expect_val("R5", 2, 16'h020C);
    expect_val("R8", SEL_IRQ, 16'h0001);
    // R9 one edge, one set
    wr(2'd2, 16'h000C);
    tick(4);
    expect_val("R9", 2, 16'h000C);
    expect_val("R9", SEL_IRQ, 16'h0000);
    ev_pin = 1'b0;
    tick(4);
    expect_val("R5", 2, 16'h000C);

    // R5 falling polarity
    wr(2'd2, 16'h0004);
    ev_pin = 1'b1;
    tick(4);
    expect_val("R5", 2, 16'h0004);
    ev_pin = 1'b0;
    tick(4);
    expect_val("R5", 2, 16'h0204);
    expect_val("R8", SEL_IRQ, 16'h0001);
    wr(2'd2, 16'h0004);
    expect_val("R6", 2, 16'h0004);

    // R3 / R8 overflow with enable
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h0003);
    wr(2'd2, 16'h0002);
    expect_val("R3", 2, 16'h0102);
    expect_val("R8", SEL_IRQ, 16'h0001);

    tick(2);
    done = 1'b1;
    report();
  end

endmodule